// File: doc/BRIEF.md
# Page Write Collector and Program Timer

This block sits behind the serial command front-end of a byte-addressed non-volatile store. Once a write instruction's address phase is decoded, the front-end gives the block the start address and then strobes each received data byte. The block keeps the bytes in a buffer the size of one page. A write pointer covers only the low offset bits, so a long burst wraps inside the page and replaces bytes it wrote before. The page number stays fixed.

When the front-end reports that chip select went high, the block decides whether to program. Three conditions must all hold: the rise came exactly on a byte boundary, the write-enable latch was set, and at least one byte was collected. If any condition fails, the buffer is dropped. If all hold, a self-timed cycle of a fixed number of system clocks begins and the busy output stays high for that whole cycle.

During the first part of the cycle, the buffer is swept through the array write port in ascending offset order. Each collected byte is written once, unless the protection block withholds its permit for that address. On the clock in which busy drops, a one-cycle pulse tells the status logic to clear the write-enable latch.

Top module: `page_prog_engine`

## Requirements
- R1: After reset, busy_o, array_we_o and wel_clr_o are all 0.
- R2: A start_i pulse (accepted only while not busy) latches start_addr_i. Each later byte_valid_i stores byte_data_i at the current offset. Only address bits 6:0 then increment, and bits 15:7 stay fixed for the whole page.
- R3: When more than 128 bytes arrive, the offset wraps from 127 to 0 and a later byte replaces the earlier one at the same offset. Only the last value at each offset is committed.
- R4: A cs_rise_i pulse with bit_phase_i equal to 0 arms a cycle, provided wel_i is 1 and at least one byte was collected. busy_o then goes high on the next clock and stays high for exactly WR_CYCLES clocks.
- R5: A cs_rise_i pulse with bit_phase_i not equal to 0 (mid-byte) discards the buffer. No cycle starts and nothing is written, and a later aligned cs_rise_i without a new start_i arms nothing.
- R6: A cs_rise_i pulse while wel_i is 0 drops the instruction. busy_o stays 0 and nothing is written.
- R7: During the first 128 clocks of a cycle, the write port visits offsets 0 to 127 in ascending order. array_addr_o is the latched page followed by the offset. A write occurs exactly once for each collected offset and never for an offset that was not received.
- R8: A collected byte is not written (array_we_o stays 0 for it) when permit_i is 0 while its address is presented.
- R9: wel_clr_o is a one-clock pulse that is high in exactly the clock where busy_o falls, and never at any other time.
- R10: While busy_o is 1, start_i, byte_valid_i and cs_rise_i have no effect. After the cycle ends, no further cycle or write follows from them.
- R11: A start_i followed by an aligned cs_rise_i with no data byte in between starts no cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Write instruction address phase done; latch start address |
| start_addr_i | input | 16 | First byte address of the write |
| byte_valid_i | input | 1 | One data byte received |
| byte_data_i | input | 8 | Received data byte |
| cs_rise_i | input | 1 | Chip select went high |
| bit_phase_i | input | 3 | Bits of the current byte already shifted; 0 means on a byte boundary |
| wel_i | input | 1 | Write-enable latch state |
| permit_i | input | 1 | Protection verdict for the address on array_addr_o |
| array_we_o | output | 1 | Array write strobe |
| array_addr_o | output | 16 | Array write address |
| array_data_o | output | 8 | Array write data |
| busy_o | output | 1 | Program cycle in progress |
| wel_clr_o | output | 1 | One-clock request to clear the write-enable latch |

## Verification
Some properties are checked by the assertions on every clock:
- array writes happen only while busy, and the sweep offset only ever steps up by one;
- the page bits of the write address do not move during a cycle;
- busy rises only after an aligned chip-select rise with the latch set;
- the counter stays inside its window;
- the latch-clear pulse coincides with the fall of busy.

Other properties can only be shown by the bench's scenarios, which compare every write against a scoreboard:
- which bytes get written, including the last-value-wins result after an in-page wrap;
- the exact busy length;
- masking by the protection verdict;
- the silence that follows a misaligned rise, a cleared latch, an empty buffer, or traffic during busy.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
  localparam int unsigned PGW_ADDR_W     = 16;
  localparam int unsigned PGW_DATA_W     = 8;
  localparam int unsigned PGW_PAGE_BYTES = 128;
  // 5 ms at 250 MHz
  localparam int unsigned PGW_WR_CYCLES  = 1250000;
endpackage

// File: rtl/pgw_page_buf.sv
module pgw_page_buf #(
  parameter int unsigned DATA_W     = pgw_pkg::PGW_DATA_W,
  parameter int unsigned PAGE_BYTES = pgw_pkg::PGW_PAGE_BYTES,
  localparam int unsigned OFF_W     = $clog2(PAGE_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              wr_i,
  input  logic [OFF_W-1:0]  wr_off_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [OFF_W-1:0]  rd_off_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_vld_o
);
  logic [DATA_W-1:0] ent_q [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] vld_q;

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_ent
    logic hit;
    assign hit = wr_i && (wr_off_i == OFF_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    vld_q[g] <= 1'b0;
      else if (clr_i) vld_q[g] <= 1'b0;
      else if (hit)   vld_q[g] <= 1'b1;
    end

    always_ff @(posedge clk_i) begin
      if (hit) ent_q[g] <= wr_data_i;
    end
  end

  assign rd_data_o = ent_q[rd_off_i];
  assign rd_vld_o  = vld_q[rd_off_i];

  // R2
  clr_empties_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (vld_q == '0));
endmodule

// File: rtl/pgw_prog_timer.sv
module pgw_prog_timer #(
  parameter int unsigned PAGE_BYTES = pgw_pkg::PGW_PAGE_BYTES,
  parameter int unsigned WR_CYCLES  = pgw_pkg::PGW_WR_CYCLES,
  localparam int unsigned OFF_W     = $clog2(PAGE_BYTES),
  localparam int unsigned CNT_W     = $clog2(WR_CYCLES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             arm_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             sweep_o,
  output logic [OFF_W-1:0] sweep_off_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      done_o <= 1'b0;
      cnt_q  <= '0;
    end else begin
      done_o <= 1'b0;
      if (!busy_o) begin
        if (arm_i) begin
          busy_o <= 1'b1;
          cnt_q  <= '0;
        end
      end else if (cnt_q == CNT_W'(WR_CYCLES - 1)) begin
        busy_o <= 1'b0;
        done_o <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // commit sweep occupies the first PAGE_BYTES clocks; WR_CYCLES must exceed PAGE_BYTES
  assign sweep_o     = busy_o && (cnt_q < CNT_W'(PAGE_BYTES));
  assign sweep_off_o = cnt_q[OFF_W-1:0];

  // R4
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (cnt_q < CNT_W'(WR_CYCLES)));
  // R9
  done_on_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);
  // R9
  done_only_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o)));
  // R7
  sweep_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sweep_o && $past(sweep_o)) |-> (sweep_off_o == $past(sweep_off_o) + 1'b1));
endmodule

// File: rtl/page_prog_engine.sv
module page_prog_engine #(
  parameter int unsigned ADDR_W     = pgw_pkg::PGW_ADDR_W,
  parameter int unsigned DATA_W     = pgw_pkg::PGW_DATA_W,
  parameter int unsigned PAGE_BYTES = pgw_pkg::PGW_PAGE_BYTES,
  parameter int unsigned WR_CYCLES  = pgw_pkg::PGW_WR_CYCLES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic              byte_valid_i,
  input  logic [DATA_W-1:0] byte_data_i,
  input  logic              cs_rise_i,
  input  logic [2:0]        bit_phase_i,
  input  logic              wel_i,
  input  logic              permit_i,
  output logic              array_we_o,
  output logic [ADDR_W-1:0] array_addr_o,
  output logic [DATA_W-1:0] array_data_o,
  output logic              busy_o,
  output logic              wel_clr_o
);
  localparam int unsigned OFF_W  = $clog2(PAGE_BYTES);
  localparam int unsigned PAGE_W = ADDR_W - OFF_W;

  logic [PAGE_W-1:0] page_q;
  logic [OFF_W-1:0]  ptr_q;
  logic              collect_q, any_q;
  logic              take_start, take_byte, take_close, arm;
  logic              sweep;
  logic [OFF_W-1:0]  sweep_off;
  logic              rd_vld;

  assign take_start = start_i && !busy_o;
  assign take_byte  = byte_valid_i && collect_q && !busy_o && !start_i;
  assign take_close = cs_rise_i && collect_q && !busy_o && !start_i;
  assign arm        = take_close && (bit_phase_i == 3'd0) && wel_i && any_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      page_q    <= '0;
      ptr_q     <= '0;
      collect_q <= 1'b0;
      any_q     <= 1'b0;
    end else if (take_start) begin
      page_q    <= start_addr_i[ADDR_W-1:OFF_W];
      ptr_q     <= start_addr_i[OFF_W-1:0];
      collect_q <= 1'b1;
      any_q     <= 1'b0;
    end else if (take_close) begin
      collect_q <= 1'b0;
    end else if (take_byte) begin
      ptr_q <= ptr_q + 1'b1;  // wraps inside the page
      any_q <= 1'b1;
    end
  end

  pgw_page_buf #(
    .DATA_W     (DATA_W),
    .PAGE_BYTES (PAGE_BYTES)
  ) i_buf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (take_start),
    .wr_i      (take_byte),
    .wr_off_i  (ptr_q),
    .wr_data_i (byte_data_i),
    .rd_off_i  (sweep_off),
    .rd_data_o (array_data_o),
    .rd_vld_o  (rd_vld)
  );

  pgw_prog_timer #(
    .PAGE_BYTES (PAGE_BYTES),
    .WR_CYCLES  (WR_CYCLES)
  ) i_timer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .arm_i       (arm),
    .busy_o      (busy_o),
    .done_o      (wel_clr_o),
    .sweep_o     (sweep),
    .sweep_off_o (sweep_off)
  );

  assign array_addr_o = {page_q, sweep_off};
  assign array_we_o   = sweep && rd_vld && permit_i;

  // R7
  we_in_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    array_we_o |-> busy_o);
  // R10
  page_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(array_addr_o[ADDR_W-1:OFF_W]));
  // R4
  arm_cond_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(cs_rise_i && wel_i && (bit_phase_i == 3'd0)));
  // R5
  no_arm_mid_byte_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_rise_i && (bit_phase_i != 3'd0) && !busy_o) |=> !busy_o);
endmodule

// File: tb/test_page_prog_engine.sv
module test_page_prog_engine;
  localparam int unsigned WR = 200;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [15:0] start_addr_i = '0;
  logic        byte_valid_i = 1'b0;
  logic [7:0]  byte_data_i = '0;
  logic        cs_rise_i = 1'b0;
  logic [2:0]  bit_phase_i = '0;
  logic        wel_i = 1'b0;
  logic        permit_i;
  logic        array_we_o;
  logic [15:0] array_addr_o;
  logic [7:0]  array_data_o;
  logic        busy_o, wel_clr_o;

  logic        prot_on = 1'b0;
  logic [15:0] prot_lo = 16'hFFFF;
  assign permit_i = !(prot_on && (array_addr_o >= prot_lo));

  always #2 clk_i = ~clk_i;

  page_prog_engine #(.WR_CYCLES(WR)) i_page_prog_engine (.*);

  int checks = 0;
  int fails  = 0;
  logic [23:0] exp_q[$];
  logic [7:0]  m_data [128];
  logic        m_vld  [128];
  logic [8:0]  m_page;
  logic [6:0]  m_ptr;
  logic        m_collect = 1'b0;
  logic        m_any = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  task automatic step();
    @(posedge clk_i); #1;
  endtask

  task automatic do_start(input logic [15:0] a);
    step(); start_i = 1'b1; start_addr_i = a;
    step(); start_i = 1'b0;
    if (!busy_o) begin
      m_page = a[15:7]; m_ptr = a[6:0]; m_collect = 1'b1; m_any = 1'b0;
      for (int i = 0; i < 128; i++) m_vld[i] = 1'b0;
    end
  endtask

  task automatic send_byte(input logic [7:0] d);
    byte_valid_i = 1'b1; byte_data_i = d;
    step(); byte_valid_i = 1'b0;
    if (m_collect && !busy_o) begin
      m_data[m_ptr] = d; m_vld[m_ptr] = 1'b1; m_ptr = m_ptr + 7'd1; m_any = 1'b1;
    end
  endtask

  task automatic cs_up(input logic [2:0] ph);
    bit was_busy;
    was_busy = busy_o;
    cs_rise_i = 1'b1; bit_phase_i = ph;
    step(); cs_rise_i = 1'b0; bit_phase_i = '0;
    if (m_collect && !was_busy) begin
      if (ph == 0 && wel_i && m_any)
        for (int i = 0; i < 128; i++)
          if (m_vld[i] && !(prot_on && ({m_page, 7'(i)} >= prot_lo)))
            exp_q.push_back({m_page, 7'(i), m_data[i]});
      m_collect = 1'b0;
    end
  endtask

  task automatic wait_idle();
    while (busy_o) @(negedge clk_i);
    repeat (3) @(negedge clk_i);
  endtask

  // monitor: scoreboard compare, busy length, clear pulse
  int  run = 0;
  bit  busy_prev = 1'b0;
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (array_we_o) begin
        if (exp_q.size() == 0) chk(1'b0, "R7 unexpected write", int'({array_addr_o, array_data_o}), 0);
        else begin
          logic [23:0] e;
          e = exp_q.pop_front();
          // R2 R3 R7 R8
          chk({array_addr_o, array_data_o} == e, "R7 write", int'({array_addr_o, array_data_o}), int'(e));
        end
      end
      if (busy_o) run++;
      if (busy_prev && !busy_o) begin
        chk(run == WR, "R4 busy length", run, WR);
        chk(wel_clr_o == 1'b1, "R9 clear pulse", wel_clr_o, 1);
        chk(exp_q.size() == 0, "R7 missing writes", exp_q.size(), 0);
        run = 0;
      end else if (wel_clr_o) begin
        chk(1'b0, "R9 stray clear pulse", 1, 0);
      end
      busy_prev = busy_o;
    end
  end

  initial begin
    #(4 * 150000);
    chk(1'b0, "watchdog", 0, 1);
    finish_up();
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    @(negedge clk_i);
    // R1
    chk(busy_o == 0, "R1 busy", busy_o, 0);
    chk(array_we_o == 0, "R1 we", array_we_o, 0);
    chk(wel_clr_o == 0, "R1 wel_clr", wel_clr_o, 0);

    // R2 R4 R7 R9: short burst, then R10 traffic while busy
    wel_i = 1'b1;
    do_start(16'h1234);
    send_byte(8'hA1); send_byte(8'hB2); send_byte(8'hC3);
    cs_up(3'd0);
    @(negedge clk_i);
    chk(busy_o == 1, "R4 busy rises", busy_o, 1);
    repeat (20) step();
    // R10
    do_start(16'h0100); send_byte(8'h55); send_byte(8'h66); cs_up(3'd0);
    wait_idle();
    repeat (10) @(negedge clk_i);
    chk(busy_o == 0, "R10 no cycle from busy traffic", busy_o, 0);
    cs_up(3'd0);
    repeat (5) @(negedge clk_i);
    chk(busy_o == 0, "R10 no late arm", busy_o, 0);

    // R3: 130 bytes from offset 7E wrap and overwrite
    do_start(16'h8F7E);
    for (int i = 0; i < 130; i++) send_byte(8'(i * 3 + 1));
    cs_up(3'd0);
    wait_idle();

    // R5: mid-byte rise discards
    do_start(16'h2000); send_byte(8'h11); cs_up(3'd3);
    repeat (5) @(negedge clk_i);
    chk(busy_o == 0, "R5 mid-byte no cycle", busy_o, 0);
    cs_up(3'd0);
    repeat (5) @(negedge clk_i);
    chk(busy_o == 0, "R5 buffer discarded", busy_o, 0);

    // R6: latch clear drops write
    wel_i = 1'b0;
    do_start(16'h3000); send_byte(8'h22); cs_up(3'd0);
    repeat (5) @(negedge clk_i);
    chk(busy_o == 0, "R6 no cycle without latch", busy_o, 0);
    wel_i = 1'b1;

    // R11: empty buffer
    do_start(16'h4000); cs_up(3'd0);
    repeat (5) @(negedge clk_i);
    chk(busy_o == 0, "R11 empty no cycle", busy_o, 0);

    // R8: protected part of a page masked
    prot_on = 1'b1; prot_lo = 16'hC020;
    do_start(16'hC010);
    for (int i = 0; i < 32; i++) send_byte(8'(8'h80 + i));
    cs_up(3'd0);
    wait_idle();
    chk(exp_q.size() == 0, "R8 queue drained", exp_q.size(), 0);
    prot_on = 1'b0;

    repeat (5) @(negedge clk_i);
    finish_up();
  end
endmodule